// File: doc/BRIEF.md
# Reconfigurable Multi-Operand Pipelined Adder

The block adds every summand packed into a 128-bit input vector and returns one total. A two-bit width select, sampled with each vector, decides how the vector is cut: sixteen 8-bit summands, eight 16-bit summands or four 32-bit summands. Summands are unsigned, and the total is always returned zero-extended to 34 bits.

The adder works on 4-bit digits. Eight carry-save blocks each reduce four 4-bit nibbles to a 6-bit count. A routing stage in front of them picks, for the selected width, which nibbles meet in the same block, so that each block only ever sees nibbles of equal weight. Later stages merge the counts of equal weight and then combine the weighted digit sums into the final total. A register sits between every pair of levels. Every width therefore runs through the same six stages. A new vector may enter on every clock, and results leave in the order the vectors arrived.

Top module: `madd_tree`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_vld` is 0 and `out_sum` is 0.
- R2: With `wsel` = 2'b00 the result is the sum of sixteen 8-bit fields, field i being `in_vec[8i+7:8i]`, zero-extended to 34 bits.
- R3: With `wsel[0]` = 1 and `wsel[1]` = 0 the result is the sum of eight 16-bit fields, field i being `in_vec[16i+15:16i]`.
- R4: With `wsel` = 2'b11 the result is the sum of four 32-bit fields, field i being `in_vec[32i+31:32i]`, without loss of the top carries (34-bit result).
- R5: The code `wsel[1]` = 1 with `wsel[0]` = 0 is reserved and gives exactly the result of `wsel` = 2'b00 for the same vector.
- R6: A vector sampled with `in_vld` high at clock edge t produces `out_vld` high with its sum after edge t+5, the sixth edge counting t, in every width. `out_vld` is low at every other time.
- R7: Vectors may be presented on consecutive cycles with the width changing from one vector to the next. Each one yields its own correct result, in order, one per cycle.
- R8: While `out_vld` is low, `out_sum` keeps the last result delivered. Vectors presented with `in_vld` low change neither output.
- R9: All-ones inputs give 4080 for 8-bit, 524280 for 16-bit and 17179869180 for 32-bit summands. No carry-save block count ever exceeds 60.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input vector is valid this cycle |
| in_vec | input | 128 | Packed summands |
| wsel | input | 2 | Summand width select (see R2 to R5) |
| out_vld | output | 1 | Result valid |
| out_sum | output | 34 | Zero-extended total |

## Verification
The bench builds the block with its default parameters: a 128-bit vector and a 34-bit result. That size reaches all three widths and the reserved code, as well as the full-scale carries into bit 33. Single vectors test the exact six-cycle latency and the held output. A back-to-back stream that changes width on every cycle tests the routing and stage alignment, comparing against a reference pipeline of expected totals.

// File: rtl/madd_pkg.sv
// Shared constants, width-mode type and width-select decoding for the
// multi-operand adder. Assumes nibble-granular summands.
package madd_pkg;
    localparam int NIB_W = 4;   // digit width handled by one carry-save lane
    localparam int CSV_N = 4;   // operands per carry-save block
    localparam int CSV_W = 6;   // result width of one carry-save block

    typedef enum logic [1:0] {
        W8  = 2'd0,
        W16 = 2'd1,
        W32 = 2'd2
    } width_e;

    // Maps the two select bits onto a width; the reserved code falls to W8.
    function automatic width_e decode_width(input logic [1:0] sel);
        case (sel)
            2'b01:   decode_width = W16;
            2'b11:   decode_width = W32;
            default: decode_width = W8;
        endcase
    endfunction
endpackage

// File: rtl/madd_csv4.sv
// Four-operand 4-bit carry-save block: two 3:2 compression rows keep
// sum and carry vectors apart, and one carry-propagate add resolves them.
// Assumes unsigned operands; the result never exceeds 60.
module madd_csv4
    import madd_pkg::*;
(
    input  logic [NIB_W-1:0] op_a,
    input  logic [NIB_W-1:0] op_b,
    input  logic [NIB_W-1:0] op_c,
    input  logic [NIB_W-1:0] op_d,
    output logic [CSV_W-1:0] total
);
    logic [NIB_W:0]   row1_s;
    logic [NIB_W:0]   row1_c;
    logic [NIB_W:0]   row2_s;
    logic [CSV_W-1:0] row2_c;

    // First compression row: three operands to a sum and a shifted carry.
    always_comb begin
        row1_s = {1'b0, op_a ^ op_b ^ op_c};
        row1_c = {(op_a & op_b) | (op_a & op_c) | (op_b & op_c), 1'b0};
    end

    // Second compression row folds in the fourth operand.
    always_comb begin
        row2_s = row1_s ^ row1_c ^ {1'b0, op_d};
        row2_c = {(row1_s & row1_c) | (row1_s & {1'b0, op_d}) | (row1_c & {1'b0, op_d}), 1'b0};
    end

    // Carry resolution: one short carry-propagate add.
    always_comb begin
        total = {1'b0, row2_s} + row2_c;
    end
endmodule

// File: rtl/madd_route.sv
// Nibble router: for the chosen width, steers nibbles of equal weight into
// the same carry-save block. Block b handles digit b / G of summand group
// b % G, with G groups of four summands per digit. Lane (b,k) occupies
// bits [(b*4+k)*4 +: 4] of the output.
module madd_route
    import madd_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] vec,
    input  width_e            mode,
    output logic [DATA_W-1:0] lanes
);
    localparam int NIBS   = DATA_W / NIB_W;
    localparam int BLOCKS = NIBS / CSV_N;
    localparam int K8     = 8 / NIB_W;
    localparam int K16    = 16 / NIB_W;
    localparam int K32    = 32 / NIB_W;
    localparam int G8     = BLOCKS / K8;
    localparam int G16    = BLOCKS / K16;
    localparam int G32    = BLOCKS / K32;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        for (genvar k = 0; k < CSV_N; k++) begin : g_lane
            localparam int I8  = ((b % G8)  * CSV_N + k) * K8  + b / G8;
            localparam int I16 = ((b % G16) * CSV_N + k) * K16 + b / G16;
            localparam int I32 = ((b % G32) * CSV_N + k) * K32 + b / G32;
            // Per-lane demultiplexing of the source nibble by width.
            assign lanes[(b*CSV_N+k)*NIB_W +: NIB_W] =
                (mode == W32) ? vec[I32*NIB_W +: NIB_W] :
                (mode == W16) ? vec[I16*NIB_W +: NIB_W] :
                                vec[I8*NIB_W  +: NIB_W];
        end
    end
endmodule

// File: rtl/madd_tree.sv
// Reconfigurable multi-operand adder, six register stages:
// input, carry-save counts, pair merge, digit select, weighted pairs, total.
// Each stage loads only when its predecessor holds valid data, so the
// output holds between results. Tree shape assumes the default 128-bit
// vector (eight carry-save blocks).
module madd_tree
    import madd_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int SUM_W  = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_vec,
    input  logic [1:0]        wsel,
    output logic              out_vld,
    output logic [SUM_W-1:0]  out_sum
);
    localparam int NIBS   = DATA_W / NIB_W;
    localparam int BLOCKS = NIBS / CSV_N;
    localparam int L3_W   = CSV_W + 1;
    localparam int DG_W   = CSV_W + 2;
    localparam int E_W    = DG_W + NIB_W + 1;
    localparam int PAIRS  = BLOCKS / 2;

    logic                    v1_q, v2_q, v3_q, v4_q, v5_q, v6_q;
    logic [DATA_W-1:0]       vec1_q;
    width_e                  mode1_q, mode2_q, mode3_q;
    logic [DATA_W-1:0]       lanes;
    logic [BLOCKS*CSV_W-1:0] blk_c;
    logic [BLOCKS*CSV_W-1:0] blk2_q;
    logic [L3_W-1:0]         lvl3_c [BLOCKS];
    logic [L3_W-1:0]         lvl3_q [BLOCKS];
    logic [DG_W-1:0]         dig_c  [BLOCKS];
    logic [DG_W-1:0]         dig_q  [BLOCKS];
    logic [E_W-1:0]          e_c    [PAIRS];
    logic [E_W-1:0]          e_q    [PAIRS];
    logic [SUM_W-1:0]        sum_c;
    logic [SUM_W-1:0]        sum_q;

    // Stage 1: capture the vector and decoded width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            vec1_q  <= '0;
            mode1_q <= W8;
        end else begin
            v1_q <= in_vld;
            if (in_vld) begin
                vec1_q  <= in_vec;
                mode1_q <= decode_width(wsel);
            end
        end
    end

    madd_route #(.DATA_W(DATA_W)) u_route (
        .vec   (vec1_q),
        .mode  (mode1_q),
        .lanes (lanes)
    );

    for (genvar b = 0; b < BLOCKS; b++) begin : g_csv
        madd_csv4 u_csv (
            .op_a  (lanes[(b*CSV_N+0)*NIB_W +: NIB_W]),
            .op_b  (lanes[(b*CSV_N+1)*NIB_W +: NIB_W]),
            .op_c  (lanes[(b*CSV_N+2)*NIB_W +: NIB_W]),
            .op_d  (lanes[(b*CSV_N+3)*NIB_W +: NIB_W]),
            .total (blk_c[b*CSV_W +: CSV_W])
        );
    end

    // Stage 2: register the carry-save block counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q    <= 1'b0;
            blk2_q  <= '0;
            mode2_q <= W8;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                blk2_q  <= blk_c;
                mode2_q <= mode1_q;
            end
        end
    end

    // Level 3: merge neighbouring blocks of equal weight, or pass through.
    always_comb begin
        for (int i = 0; i < BLOCKS; i++) lvl3_c[i] = '0;
        if (mode2_q == W32) begin
            for (int i = 0; i < BLOCKS; i++)
                lvl3_c[i] = {1'b0, blk2_q[i*CSV_W +: CSV_W]};
        end else begin
            for (int i = 0; i < PAIRS; i++)
                lvl3_c[i] = {1'b0, blk2_q[(2*i)*CSV_W +: CSV_W]}
                          + {1'b0, blk2_q[(2*i+1)*CSV_W +: CSV_W]};
        end
    end

    // Stage 3: register merged counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3_q    <= 1'b0;
            mode3_q <= W8;
            for (int i = 0; i < BLOCKS; i++) lvl3_q[i] <= '0;
        end else begin
            v3_q <= v2_q;
            if (v2_q) begin
                mode3_q <= mode2_q;
                for (int i = 0; i < BLOCKS; i++) lvl3_q[i] <= lvl3_c[i];
            end
        end
    end

    // Level 4: form one count per digit weight.
    always_comb begin
        for (int i = 0; i < BLOCKS; i++) dig_c[i] = '0;
        case (mode3_q)
            W32: for (int i = 0; i < BLOCKS; i++) dig_c[i] = {1'b0, lvl3_q[i]};
            W16: for (int i = 0; i < PAIRS; i++)  dig_c[i] = {1'b0, lvl3_q[i]};
            default:
                for (int i = 0; i < BLOCKS / 4; i++)
                    dig_c[i] = {1'b0, lvl3_q[2*i]} + {1'b0, lvl3_q[2*i+1]};
        endcase
    end

    // Stage 4: register digit counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v4_q <= 1'b0;
            for (int i = 0; i < BLOCKS; i++) dig_q[i] <= '0;
        end else begin
            v4_q <= v3_q;
            if (v3_q)
                for (int i = 0; i < BLOCKS; i++) dig_q[i] <= dig_c[i];
        end
    end

    // Level 5: combine each pair of adjacent digits by their 4-bit offset.
    always_comb begin
        for (int i = 0; i < PAIRS; i++)
            e_c[i] = {{(E_W-DG_W){1'b0}}, dig_q[2*i]}
                   + {1'b0, dig_q[2*i+1], {NIB_W{1'b0}}};
    end

    // Stage 5: register weighted pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v5_q <= 1'b0;
            for (int i = 0; i < PAIRS; i++) e_q[i] <= '0;
        end else begin
            v5_q <= v4_q;
            if (v4_q)
                for (int i = 0; i < PAIRS; i++) e_q[i] <= e_c[i];
        end
    end

    // Level 6: final weighted total of the pairs, 8 bits apart.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < PAIRS; i++)
            sum_c = sum_c + (SUM_W'(e_q[i]) << (2 * NIB_W * i));
    end

    // Stage 6: output register, held while no result arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v6_q  <= 1'b0;
            sum_q <= '0;
        end else begin
            v6_q <= v5_q;
            if (v5_q) sum_q <= sum_c;
        end
    end

    assign out_vld = v6_q;
    assign out_sum = sum_q;
endmodule

// File: rtl/madd_tree_chk.sv
// Property checker for madd_tree, attached by bind. Keeps its own short
// history of the input strobe to judge output timing.
module madd_tree_chk #(
    parameter int BLOCKS = 8,
    parameter int SUM_W  = 34
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_vld,
    input logic                out_vld,
    input logic [SUM_W-1:0]    out_sum,
    input logic [BLOCKS*6-1:0] blk_sum
);
    localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(64'd17179869180);

    logic [5:0] vld_hist;

    // Six-cycle record of accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_hist <= '0;
        else        vld_hist <= {vld_hist[4:0], in_vld};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_vld);

    // R6
    latency_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == vld_hist[5]);

    // R8
    hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_sum));

    // R9
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_sum <= SUM_MAX);

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        // R9
        csv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            blk_sum[b*6 +: 6] <= 6'd60);
    end
endmodule

bind madd_tree madd_tree_chk #(.BLOCKS(BLOCKS), .SUM_W(SUM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_sum (out_sum),
    .blk_sum (blk2_q)
);

// File: tb/sim_madd_tree.sv
// Directed bench for madd_tree: one task per scenario, each checking itself.
module sim_madd_tree;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [127:0] in_vec = '0;
    logic [1:0]   wsel = 2'b00;
    logic         out_vld;
    logic [33:0]  out_sum;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    logic        m_vld [6];
    logic [33:0] m_sum [6];

    always #5 clk = ~clk;

    madd_tree u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_vec(in_vec),
        .wsel(wsel), .out_vld(out_vld), .out_sum(out_sum)
    );

    // Expected total from the field definitions of R2 to R5.
    function automatic logic [33:0] ref_sum(input logic [127:0] v, input logic [1:0] s);
        logic [33:0] acc = '0;
        if (s == 2'b11)
            for (int i = 0; i < 4; i++)  acc += 34'(v[32*i +: 32]);
        else if (s == 2'b01)
            for (int i = 0; i < 8; i++)  acc += 34'(v[16*i +: 16]);
        else
            for (int i = 0; i < 16; i++) acc += 34'(v[8*i +: 8]);
        return acc;
    endfunction

    // Reference pipeline of expected results, six deep.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin m_vld[i] <= 1'b0; m_sum[i] <= '0; end
        end else begin
            m_vld[0] <= in_vld;
            m_sum[0] <= ref_sum(in_vec, wsel);
            for (int i = 1; i < 6; i++) begin m_vld[i] <= m_vld[i-1]; m_sum[i] <= m_sum[i-1]; end
        end
    end

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd_vec();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            v[32*i +: 32] = seed ^ {seed[15:0], seed[31:16]};
        end
        return v;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 vld in reset", 34'(out_vld), 34'd0);
        check("R1 sum in reset", out_sum, 34'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after reset", 34'(out_vld), 34'd0);
        check("R1 sum after reset", out_sum, 34'd0);
    endtask

    // One vector; verifies exact latency (R6) and the value against exp.
    task automatic t_single(input logic [127:0] v, input logic [1:0] s,
                            input logic [33:0] exp, input string req);
        @(negedge clk);
        in_vec = v; wsel = s; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0; in_vec = ~v;
        repeat (4) @(negedge clk);
        check("R6 not early", 34'(out_vld), 34'd0);
        @(negedge clk);
        check("R6 valid at six", 34'(out_vld), 34'd1);
        check(req, out_sum, exp);
        @(negedge clk);
        check("R6 single pulse", 34'(out_vld), 34'd0);
    endtask

    task automatic t_widths();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'(i * 17 + 3);
        t_single(v, 2'b00, ref_sum(v, 2'b00), "R2 ramp bytes");
        v = rnd_vec();
        t_single(v, 2'b00, ref_sum(v, 2'b00), "R2 random");
        t_single(v, 2'b01, ref_sum(v, 2'b01), "R3 random");
        t_single(v, 2'b11, ref_sum(v, 2'b11), "R4 random");
        v = 128'h0000_0001_8000_0000_FFFF_0000_0000_FFFF;
        t_single(v, 2'b01, ref_sum(v, 2'b01), "R3 sparse halves");
        t_single(v, 2'b11, ref_sum(v, 2'b11), "R4 sparse words");
        v = rnd_vec();
        t_single(v, 2'b10, ref_sum(v, 2'b00), "R5 reserved as bytes");
    endtask

    task automatic t_full_scale();
        t_single({128{1'b1}}, 2'b00, 34'd4080, "R9 bytes all ones");
        t_single({128{1'b1}}, 2'b01, 34'd524280, "R9 halves all ones");
        t_single({128{1'b1}}, 2'b11, 34'd17179869180, "R9 words all ones");
        t_single('0, 2'b11, 34'd0, "R4 all zeros");
    endtask

    // Idle vectors must not disturb the held result.
    task automatic t_hold();
        logic [127:0] v;
        logic [33:0]  last;
        v = rnd_vec();
        t_single(v, 2'b01, ref_sum(v, 2'b01), "R3 before hold");
        last = ref_sum(v, 2'b01);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_vec = rnd_vec(); wsel = 2'(i);
            check("R8 vld low while idle", 34'(out_vld), 34'd0);
            check("R8 sum held while idle", out_sum, last);
        end
    endtask

    // Back-to-back vectors with width changing each cycle.
    task automatic t_stream();
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            check("R7 stream valid", 34'(out_vld), 34'(m_vld[5]));
            if (m_vld[5]) check("R7 stream sum", out_sum, m_sum[5]);
            if (c < 30) begin
                in_vld = (c % 7) != 5;
                in_vec = rnd_vec();
                wsel   = 2'(c % 4);
            end else begin
                in_vld = 1'b0;
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_widths();
        t_full_scale();
        t_hold();
        t_stream();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule